// File: doc/BRIEF.md
# Programmable IO Window Address Decoder

This block steers each incoming transaction address to a target ID. A bank of windows, each set up by software, holds an inclusive start and end address in 1 MiB units, an enable flag and a target ID. When a lookup is presented, every enabled window compares the upper address bits against its bounds at the same time. The lowest-numbered matching window supplies the target. When nothing matches, a global fallback target is returned.

Configuration goes through a plain 32-bit register write port with a combinational read-back. Each window takes a 16-byte slot in the register space. Lookups carry a one-cycle valid strobe, and the result is registered and appears on the next clock edge.

Top module: `iowin_decoder`

## Requirements
- R1: After reset every window is disabled with zero bounds and zero target, the fallback target is zero, every register reads zero and `res_vld` is low.
- R2: Window w owns byte offsets 16*w to 16*w+15. Offset +0x0 holds the start field in bits 23:4 and the enable in bit 0. Offset +0x8 holds the end field in bits 23:4. Offset +0xC holds the target ID in bits TGT_W-1:0. The fallback target sits at offset 16*NUM_WIN in bits TGT_W-1:0. All other bits of these registers read zero.
- R3: Reads of any other offset return zero, and writes to such an offset change no register and no lookup result. This covers +0x4 in a slot, offsets that are not word aligned, and offsets past the fallback register.
- R4: An enabled window matches when address bits 39:20 are at least its start field and at most its end field. Both bounds are inclusive.
- R5: A window whose enable bit is clear never matches. Clearing only the enable bit leaves the start field readable as it was written.
- R6: When several enabled windows match, `res_win` and `res_tgt` come from the lowest-numbered one.
- R7: When no enabled window matches, `res_hit` is 0, `res_win` is 0 and `res_tgt` equals the fallback target.
- R8: A lookup with `req_vld` high produces `res_vld` high on the next clock edge and on that edge only. Without a lookup, `res_hit`, `res_win` and `res_tgt` keep their values.
- R9: Window 0 is programmed and decodes exactly like any other window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_vld | input | 1 | Lookup strobe |
| req_addr | input | ADDR_W | Lookup address |
| res_vld | output | 1 | Lookup result valid, one cycle after `req_vld` |
| res_hit | output | 1 | An enabled window matched |
| res_win | output | $clog2(NUM_WIN) | Index of the matching window, 0 when none matched |
| res_tgt | output | TGT_W | Selected target ID |

## Verification
The bench uses the defaults: 16 windows, a 40-bit address and 4-bit targets. With these, the top slot (window 15), the fallback register at 0x100 and the unmapped gap just past it can all be reached. Random bounds are kept to a narrow field range so that windows overlap often. This exercises the priority order among all 16 windows, empty windows whose end lies below their start, and lookups that land exactly on a start or end field.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // sub-offsets inside one 16-byte window slot
  localparam logic [3:0] SUB_LO  = 4'h0;
  localparam logic [3:0] SUB_HI  = 4'h8;
  localparam logic [3:0] SUB_CTL = 4'hC;
  // bit positions inside the bound registers
  localparam int EN_BIT  = 0;
  localparam int FLD_LSB = 4;
  // window granularity: 1 MiB
  localparam int GRAN_SH = 20;
endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  parameter int REG_AW  = 12,
  parameter int FLD_W   = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [REG_AW-1:0]               cfg_addr,
  input  logic [31:0]                     cfg_wdata,
  output logic [31:0]                     cfg_rdata,
  output logic [NUM_WIN-1:0][FLD_W-1:0]   start_o,
  output logic [NUM_WIN-1:0][FLD_W-1:0]   end_o,
  output logic [NUM_WIN-1:0]              en_o,
  output logic [NUM_WIN-1:0][TGT_W-1:0]   tgt_o,
  output logic [TGT_W-1:0]                dflt_o
);
  localparam int SLOT_W   = REG_AW - 4;
  localparam int WIN_W    = $clog2(NUM_WIN);
  localparam int DFLT_OFS = NUM_WIN * 16;

  logic [SLOT_W-1:0] slot;
  logic [3:0]        sub;
  logic              slot_ok;
  logic              dflt_sel;
  logic [WIN_W-1:0]  slot_idx;

  assign slot     = cfg_addr[REG_AW-1:4];
  assign sub      = cfg_addr[3:0];
  assign slot_ok  = (32'(slot) < 32'(NUM_WIN));
  assign dflt_sel = (32'(cfg_addr) == 32'(DFLT_OFS));
  assign slot_idx = slot[WIN_W-1:0];

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:FLD_LSB+FLD_W], cfg_wdata[FLD_LSB-1:1]};

  // per-window storage with explicit write enables
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic             wr_lo, wr_hi, wr_ctl;
    logic [FLD_W-1:0] start_q, end_q;
    logic             en_q;
    logic [TGT_W-1:0] tgt_q;

    always_comb begin
      wr_lo  = cfg_we && slot_ok && (32'(slot) == 32'(w)) && (sub == SUB_LO);
      wr_hi  = cfg_we && slot_ok && (32'(slot) == 32'(w)) && (sub == SUB_HI);
      wr_ctl = cfg_we && slot_ok && (32'(slot) == 32'(w)) && (sub == SUB_CTL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        en_q    <= 1'b0;
      end else if (wr_lo) begin
        start_q <= cfg_wdata[FLD_LSB +: FLD_W];
        en_q    <= cfg_wdata[EN_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     end_q <= '0;
      else if (wr_hi) end_q <= cfg_wdata[FLD_LSB +: FLD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_q <= '0;
      else if (wr_ctl) tgt_q <= cfg_wdata[TGT_W-1:0];
    end

    assign start_o[w] = start_q;
    assign end_o[w]   = end_q;
    assign en_o[w]    = en_q;
    assign tgt_o[w]   = tgt_q;
  end

  logic wr_dflt;
  logic [TGT_W-1:0] dflt_q;
  assign wr_dflt = cfg_we && dflt_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dflt_q <= '0;
    else if (wr_dflt) dflt_q <= cfg_wdata[TGT_W-1:0];
  end
  assign dflt_o = dflt_q;

  // combinational read-back
  always_comb begin
    cfg_rdata = '0;
    if (slot_ok) begin
      case (sub)
        SUB_LO: begin
          cfg_rdata[FLD_LSB +: FLD_W] = start_o[slot_idx];
          cfg_rdata[EN_BIT]           = en_o[slot_idx];
        end
        SUB_HI:  cfg_rdata[FLD_LSB +: FLD_W] = end_o[slot_idx];
        SUB_CTL: cfg_rdata[TGT_W-1:0]        = tgt_o[slot_idx];
        default: cfg_rdata = '0;
      endcase
    end else if (dflt_sel) begin
      cfg_rdata[TGT_W-1:0] = dflt_q;
    end
  end
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int NUM_WIN = 16,
  parameter int FLD_W   = 20
) (
  input  logic [FLD_W-1:0]              fld,
  input  logic [NUM_WIN-1:0][FLD_W-1:0] start_i,
  input  logic [NUM_WIN-1:0][FLD_W-1:0] end_i,
  input  logic [NUM_WIN-1:0]            en_i,
  output logic [NUM_WIN-1:0]            match_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic above_lo, below_hi;
    assign above_lo   = (fld >= start_i[w]);
    assign below_hi   = (fld <= end_i[w]);
    assign match_o[w] = en_i[w] && above_lo && below_hi;
  end
endmodule

// File: rtl/iowin_prio.sv
module iowin_prio #(
  parameter int NUM_WIN = 16,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] match_i,
  output logic               hit_o,
  output logic [WIN_W-1:0]   idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        hit_o = 1'b1;
        idx_o = WIN_W'(w);
      end
    end
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int ADDR_W  = 40,
  parameter int TGT_W   = 4,
  parameter int REG_AW  = 12,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_vld,
  output logic              res_hit,
  output logic [WIN_W-1:0]  res_win,
  output logic [TGT_W-1:0]  res_tgt
);
  localparam int FLD_W = ADDR_W - GRAN_SH;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_WIN-1:0][FLD_W-1:0] start_v, end_v;
  logic [NUM_WIN-1:0]            en_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0] tgt_v;
  logic [TGT_W-1:0]              dflt_tgt;
  logic [NUM_WIN-1:0]            match_vec;
  logic                          any_hit;
  logic [WIN_W-1:0]              hit_idx;

  iowin_regfile #(
    .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .REG_AW(REG_AW), .FLD_W(FLD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start_o(start_v), .end_o(end_v), .en_o(en_vec), .tgt_o(tgt_v),
    .dflt_o(dflt_tgt)
  );

  logic [FLD_W-1:0] req_fld;
  logic             unused_low_addr;
  assign req_fld         = req_addr[ADDR_W-1:GRAN_SH];
  assign unused_low_addr = ^req_addr[GRAN_SH-1:0];

  iowin_match #(.NUM_WIN(NUM_WIN), .FLD_W(FLD_W)) u_match (
    .fld(req_fld), .start_i(start_v), .end_i(end_v), .en_i(en_vec),
    .match_o(match_vec)
  );

  iowin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .match_i(match_vec), .hit_o(any_hit), .idx_o(hit_idx)
  );

  // next-state for the result stage
  logic [TGT_W-1:0] tgt_d;
  logic [WIN_W-1:0] win_d;
  always_comb begin
    tgt_d = any_hit ? tgt_v[hit_idx] : dflt_tgt;
    win_d = any_hit ? hit_idx : '0;
  end

  logic             vld_q, hit_q;
  logic [WIN_W-1:0] win_q;
  logic [TGT_W-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= req_vld;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q <= 1'b0;
      win_q <= '0;
      tgt_q <= '0;
    end else if (req_vld) begin
      hit_q <= any_hit;
      win_q <= win_d;
      tgt_q <= tgt_d;
    end
  end

  assign res_vld = vld_q;
  assign res_hit = hit_q;
  assign res_win = win_q;
  assign res_tgt = tgt_q;
endmodule

// File: rtl/iowin_chk.sv
module iowin_chk #(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               req_vld,
  input logic               res_vld,
  input logic               res_hit,
  input logic [WIN_W-1:0]   res_win,
  input logic [TGT_W-1:0]   res_tgt,
  input logic [NUM_WIN-1:0] match_vec,
  input logic [NUM_WIN-1:0] en_vec,
  input logic [TGT_W-1:0]   dflt_tgt
);
  // R8
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |=> res_vld);
  // R8
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |=> (!res_vld && $stable(res_tgt) && $stable(res_win) && $stable(res_hit)));
  // R5
  disabled_no_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_vec & ~en_vec) == '0);
  // R7
  fallback_tgt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && match_vec == '0) |=> (!res_hit && res_win == '0 && res_tgt == $past(dflt_tgt)));
  // R6
  win0_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && match_vec[0]) |=> (res_hit && res_win == '0));
  // R4
  hit_when_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && match_vec != '0) |=> res_hit);
endmodule

bind iowin_decoder iowin_chk #(.NUM_WIN(NUM_WIN), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_vld(req_vld), .res_vld(res_vld),
  .res_hit(res_hit), .res_win(res_win), .res_tgt(res_tgt),
  .match_vec(match_vec), .en_vec(en_vec), .dflt_tgt(dflt_tgt)
);

// File: tb/iowin_decoder_tb.sv
`timescale 1ns/1ps
module iowin_decoder_tb;
  localparam int NW = 16;
  localparam int AW = 40;
  localparam int TW = 4;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [RW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          req_vld;
  logic [AW-1:0] req_addr;
  logic          res_vld, res_hit;
  logic [3:0]    res_win;
  logic [TW-1:0] res_tgt;

  always #2.5 clk = ~clk;

  iowin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_vld(req_vld),
    .req_addr(req_addr), .res_vld(res_vld), .res_hit(res_hit),
    .res_win(res_win), .res_tgt(res_tgt)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the programmed state
  logic [19:0]   m_st [NW];
  logic [19:0]   m_en_fld [NW];
  logic          m_en [NW];
  logic [TW-1:0] m_tg [NW];
  logic [TW-1:0] m_dflt;

  logic          e_hit;
  logic [3:0]    e_win;
  logic [TW-1:0] e_tgt;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [RW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [RW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic prog(input int w, input logic [19:0] st, input logic en,
                      input logic [19:0] en_f, input logic [TW-1:0] tg);
    wr(RW'(w * 16 + 8), {8'h0, en_f, 4'h0});
    wr(RW'(w * 16 + 12), {28'h0, tg});
    wr(RW'(w * 16), {8'h0, st, 3'b000, en});
    m_st[w] = st; m_en[w] = en; m_en_fld[w] = en_f; m_tg[w] = tg;
  endtask

  function automatic void expect_for(input logic [19:0] f);
    e_hit = 1'b0; e_win = '0; e_tgt = m_dflt;
    for (int w = 0; w < NW; w++) begin
      if (!e_hit && m_en[w] && f >= m_st[w] && f <= m_en_fld[w]) begin
        e_hit = 1'b1; e_win = 4'(w); e_tgt = m_tg[w];
      end
    end
  endfunction

  task automatic look(input logic [AW-1:0] a, input string req);
    expect_for(a[39:20]);
    @(negedge clk);
    req_vld = 1'b1; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
    check(req, {31'h0, res_vld}, 32'h1);
    check(req, {31'h0, res_hit}, {31'h0, e_hit});
    check(req, {28'h0, res_win}, {28'h0, e_win});
    check(req, {28'h0, res_tgt}, {28'h0, e_tgt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_vld = 1'b0; req_addr = '0;
    for (int w = 0; w < NW; w++) begin
      m_st[w] = '0; m_en[w] = 1'b0; m_en_fld[w] = '0; m_tg[w] = '0;
    end
    m_dflt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 res_vld", {31'h0, res_vld}, 32'h0);
    rd_chk(12'h000, 32'h0, "R1 win0 lo");
    rd_chk(12'h0F8, 32'h0, "R1 win15 hi");
    rd_chk(12'h0AC, 32'h0, "R1 win10 ctl");
    rd_chk(12'h100, 32'h0, "R1 fallback");
    look(40'h12_3450_0000, "R1 lookup after reset");

    // R2: register layout, unused bits read zero
    wr(12'h100, 32'hFFFF_FFF9);
    m_dflt = 4'h9;
    rd_chk(12'h100, 32'h9, "R2 fallback bits");
    wr(12'h038, 32'hFFFF_FFFF);
    rd_chk(12'h038, 32'h00FF_FFF0, "R2 hi field bits 23:4");
    wr(12'h030, 32'hFFFF_FFFE);
    rd_chk(12'h030, 32'h00FF_FFF0, "R2 lo field, enable clear");
    wr(12'h03C, 32'hFFFF_FFF6);
    rd_chk(12'h03C, 32'h6, "R2 ctl target bits");
    m_st[3] = 20'hFFFFF; m_en_fld[3] = 20'hFFFFF; m_tg[3] = 4'h6; m_en[3] = 1'b0;

    // R3: unmapped offsets
    wr(12'h034, 32'hFFFF_FFFF);
    rd_chk(12'h034, 32'h0, "R3 slot +4 reads zero");
    wr(12'h031, 32'h0000_0001);
    rd_chk(12'h031, 32'h0, "R3 misaligned reads zero");
    rd_chk(12'h030, 32'h00FF_FFF0, "R3 misaligned write ignored");
    wr(12'h104, 32'h5);
    wr(12'h200, 32'h5);
    rd_chk(12'h104, 32'h0, "R3 past fallback reads zero");
    rd_chk(12'h100, 32'h9, "R3 fallback unchanged");
    look(40'hFF_FFF0_0000, "R3 window 3 still off");

    // R4: inclusive bounds
    prog(5, 20'h00100, 1'b1, 20'h001FF, 4'hA);
    look(40'h00_1000_0000, "R4 start edge");
    look(40'h00_1FFF_FFFF, "R4 end edge");
    look(40'h00_0FFF_FFFF, "R4 below start");
    look(40'h00_2000_0000, "R4 above end");

    // R5: disable keeps the stored start
    wr(12'h050, 32'h0000_1000);
    m_en[5] = 1'b0;
    rd_chk(12'h050, 32'h0000_1000, "R5 start kept after disable");
    look(40'h00_1800_0000, "R5 disabled window no hit");

    // R6: overlap priority, R9 window 0
    prog(7, 20'h00400, 1'b1, 20'h004FF, 4'h3);
    prog(2, 20'h00480, 1'b1, 20'h00500, 4'hC);
    look(40'h00_4900_0000, "R6 lower index wins");
    prog(0, 20'h00000, 1'b1, 20'hFFFFF, 4'h1);
    rd_chk(12'h000, 32'h0000_0001, "R9 window 0 lo readback");
    look(40'h00_4900_0000, "R9 window 0 wins over all");
    prog(0, 20'h00000, 1'b0, 20'h00000, 4'h0);

    // R7: fallback
    look(40'h80_0000_0000, "R7 no match uses fallback");

    // R8: timing and hold
    look(40'h00_4100_0000, "R8 result one cycle later");
    @(negedge clk);
    check("R8 res_vld single pulse", {31'h0, res_vld}, 32'h0);
    check("R8 target held", {28'h0, res_tgt}, {28'h0, e_tgt});
    check("R8 window held", {28'h0, res_win}, {28'h0, e_win});

    // random mix: overlapping windows in a narrow field range
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        int w;
        logic [19:0] s, e;
        w = $urandom_range(0, NW - 1);
        s = 20'($urandom_range(0, 63));
        e = s + 20'($urandom_range(0, 20)) - 20'($urandom_range(0, 3));
        prog(w, s, 1'($urandom_range(0, 3) != 0), e, 4'($urandom));
        rd_chk(RW'(w * 16 + 8), {8'h0, e, 4'h0}, "R2 random hi readback");
      end
      if ($urandom_range(0, 15) == 0) begin
        m_dflt = 4'($urandom);
        wr(12'h100, {28'h0, m_dflt});
      end
      look({20'($urandom_range(0, 90)), 20'($urandom)}, "R4 R6 R7 random lookup");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule